// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that keeps lines recently thrown out of a direct-mapped primary cache. The primary cache talks to it only when it misses. It presents the block address it wanted on the probe port, together with the line it is about to give up on the displaced-line port. The buffer compares the probe against every entry in parallel. On a match it returns the stored line and its dirty state. The displaced line is then written into that same slot, so the two lines trade places and no other entry is disturbed. On no match it raises a fetch request for the probed block. The displaced line is then placed in a free slot, or in the least recently used slot when the buffer is full. If the entry pushed out that way is dirty, it leaves on the write-back output.

The displaced-line port can also be driven on its own, with no probe, when the primary cache drops a line for some other reason. Each entry holds a full block address, the line data, a valid bit and a dirty bit. The entry count, the block address width and the line width are parameters. All responses are registered and appear in the cycle after the request.

Top module: `victim_cache`

## Requirements
- R1: After reset every entry is invalid. The first probe misses, and no write-back is produced.
- R2: A probe whose address matches a valid entry gives, one cycle later, `rsp_valid`=1 and `rsp_hit`=1 with that entry's data and dirty bit, and `fetch_req`=0.
- R3: A probe that matches no valid entry gives, one cycle later, `rsp_hit`=0 and `fetch_req`=1 with `fetch_addr` equal to the probed address.
- R4: On a probe hit, the displaced line given with the probe is stored in the slot the hit entry occupied. A later probe of the displaced address returns that line, and all other entries are unchanged.
- R5: On a probe miss, or on an insert with no probe, a valid displaced line goes into the lowest-numbered invalid slot. If no slot is invalid, it goes into the least recently used slot.
- R6: Recency is refreshed only by writing a slot (insert or swap). Probe misses and idle cycles leave it unchanged, and the slot evicted when the buffer is full is the one written longest ago.
- R7: A probe hit never evicts an entry and never produces a write-back, even when the buffer is full.
- R8: When an insert evicts a valid dirty entry, `wb_valid`=1 with that entry's address and data one cycle later. Evicting a clean entry gives `wb_valid`=0.
- R9: The dirty bit travels with a line through swaps. A line stored dirty is later returned with `rsp_dirty`=1, and one stored clean is returned with `rsp_dirty`=0.
- R10: A probe hit with `ins_valid`=0 removes the hit entry, so a following probe of the same address misses.
- R11: An insert with `probe_valid`=0 gives `rsp_valid`=0 and `fetch_req`=0 one cycle later.
- R12: `rsp_valid` is 1 exactly in the cycle after a cycle with `probe_valid`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_valid | input | 1 | Primary cache missed; search the buffer |
| probe_addr | input | ADDR_W | Block address being looked up |
| ins_valid | input | 1 | A displaced primary line is supplied |
| ins_addr | input | ADDR_W | Block address of the displaced line |
| ins_dirty | input | 1 | Dirty bit of the displaced line |
| ins_data | input | DATA_W | Data of the displaced line |
| rsp_valid | output | 1 | Probe result is present |
| rsp_hit | output | 1 | Probe found the block |
| rsp_dirty | output | 1 | Dirty bit of the returned line |
| rsp_data | output | DATA_W | Returned line data |
| fetch_req | output | 1 | Block must come from memory |
| fetch_addr | output | ADDR_W | Block address to fetch |
| wb_valid | output | 1 | A dirty entry left the buffer |
| wb_addr | output | ADDR_W | Block address being written back |
| wb_data | output | DATA_W | Data being written back |

## Verification
A corrupted tag, valid bit or data word in one slot shows up as a wrong hit flag or wrong data on the next probe of that block. Because responses are registered, that is exactly one cycle after the probe. A wrong recency order stays hidden until the buffer is full and an insert evicts. At that point it shows as a write-back of the wrong address, or as a later miss on a block that should have stayed. A lost dirty bit shows as a missing write-back only when that line is finally evicted, which can be many accesses later. The bench therefore runs long mixed traces on a small configuration so that every slot is evicted many times.

// File: rtl/vc_pkg.sv
// Package: shared definitions for the victim buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package vc_pkg;

    // What the buffer does with the request of one cycle
    typedef enum logic [1:0] {
        VC_IDLE   = 2'd0,   // nothing to store
        VC_SWAP   = 2'd1,   // probe hit: displaced line replaces hit slot
        VC_FILL   = 2'd2    // displaced line goes to free or LRU slot
    } vc_act_e;

    // Index width that stays legal for a single entry
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vc_match.sv
// Module: parallel address compare across all buffer entries.
// Assumes: at most one valid entry holds a given block address,
// which the primary cache guarantees by keeping lines exclusive.
module vc_match #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned IDX_W  = vc_pkg::idx_width(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr,
    input  logic [ADDR_W-1:0]              key,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx
);

    logic [ENTRIES-1:0] match_vec;

    // One comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ent_valid[g] && (ent_addr[g] == key);
    end

    // Reduce the match vector to a hit flag and an encoded slot
    always_comb begin
        hit     = |match_vec;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/vc_lru.sv
// Module: true-LRU tracking by per-slot age counters and victim choice.
// Assumes: ages form a permutation of 0..ENTRIES-1 at all times; age 0
// is most recent. Free slots are always preferred over the oldest one.
module vc_lru #(
    parameter int unsigned ENTRIES = 4,
    localparam int unsigned IDX_W  = vc_pkg::idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] ent_valid,
    output logic [IDX_W-1:0]   victim_idx
);

    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic [IDX_W-1:0]              touched_age;
    logic                          have_free;
    logic [IDX_W-1:0]              free_idx;
    logic [IDX_W-1:0]              oldest_idx;

    // Age of the slot being refreshed
    always_comb begin
        touched_age = age_q[touch_idx];
    end

    // Refresh ages: touched slot becomes youngest, younger ones grow older
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < touched_age)
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Pick the lowest free slot, else the slot with the greatest age
    always_comb begin
        have_free  = 1'b0;
        free_idx   = '0;
        oldest_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
            if (age_q[i] == IDX_W'(ENTRIES - 1)) oldest_idx = IDX_W'(i);
        end
        victim_idx = have_free ? free_idx : oldest_idx;
    end

endmodule

// File: rtl/vc_store.sv
// Module: entry storage (valid, block address, dirty, data) with one
// write port. Assumes one slot is written per cycle at most.
module vc_store #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned IDX_W  = vc_pkg::idx_width(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               widx,
    input  logic                           wvalid,
    input  logic [ADDR_W-1:0]              waddr,
    input  logic                           wdirty,
    input  logic [DATA_W-1:0]              wdata,
    output logic [ENTRIES-1:0]             ent_valid,
    output logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr,
    output logic [ENTRIES-1:0]             ent_dirty,
    output logic [ENTRIES-1:0][DATA_W-1:0] ent_data
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Hold one entry; cleared by reset, loaded when selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[g] <= 1'b0;
                ent_addr[g]  <= '0;
                ent_dirty[g] <= 1'b0;
                ent_data[g]  <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                ent_valid[g] <= wvalid;
                ent_addr[g]  <= waddr;
                ent_dirty[g] <= wvalid && wdirty;
                ent_data[g]  <= wdata;
            end
        end
    end

endmodule

// File: rtl/victim_cache.sv
// Module: fully associative victim buffer beside a direct-mapped cache.
// A probe hit swaps the displaced primary line into the hit slot; a
// probe miss requests a fetch and files the displaced line into a free
// or least recently used slot, writing back a dirty evictee.
// Assumes: the primary cache keeps its lines and the buffer's exclusive
// and never probes the address it is displacing.
module victim_cache #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              ins_dirty,
    input  logic [DATA_W-1:0] ins_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_dirty,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    import vc_pkg::*;

    localparam int unsigned IDX_W = idx_width(ENTRIES);

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [ENTRIES-1:0]             ent_dirty;
    logic [ENTRIES-1:0][DATA_W-1:0] ent_data;
    logic                           hit;
    logic [IDX_W-1:0]               hit_idx;
    logic [IDX_W-1:0]               victim_idx;
    vc_act_e                        act;
    logic [IDX_W-1:0]               slot;
    logic                           we;
    logic                           evict_dirty;

    vc_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .widx(slot),
        .wvalid(ins_valid), .waddr(ins_addr), .wdirty(ins_dirty),
        .wdata(ins_data), .ent_valid(ent_valid), .ent_addr(ent_addr),
        .ent_dirty(ent_dirty), .ent_data(ent_data)
    );

    vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .ent_valid(ent_valid), .ent_addr(ent_addr), .key(probe_addr),
        .hit(hit), .hit_idx(hit_idx)
    );

    vc_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch(we), .touch_idx(slot),
        .ent_valid(ent_valid), .victim_idx(victim_idx)
    );

    // Decide this cycle's action and the slot it writes
    always_comb begin
        if (probe_valid && hit) begin
            act = VC_SWAP;
            slot = hit_idx;
        end else if (ins_valid) begin
            act = VC_FILL;
            slot = victim_idx;
        end else begin
            act = VC_IDLE;
            slot = victim_idx;
        end
        we          = (act != VC_IDLE);
        evict_dirty = (act == VC_FILL) && ent_valid[victim_idx]
                      && ent_dirty[victim_idx];
    end

    // Register the probe response and the fetch request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_dirty  <= 1'b0;
            rsp_data   <= '0;
            fetch_req  <= 1'b0;
            fetch_addr <= '0;
        end else begin
            rsp_valid  <= probe_valid;
            rsp_hit    <= probe_valid && hit;
            rsp_dirty  <= probe_valid && hit && ent_dirty[hit_idx];
            rsp_data   <= ent_data[hit_idx];
            fetch_req  <= probe_valid && !hit;
            fetch_addr <= probe_addr;
        end
    end

    // Register the write-back of a dirty entry pushed out by a fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= evict_dirty;
            wb_addr  <= ent_addr[victim_idx];
            wb_data  <= ent_data[victim_idx];
        end
    end

endmodule

// File: rtl/vc_checker.sv
// Module: port-level protocol checks for the victim buffer, bound to it.
// Assumes: same parameters as the bound instance.
module vc_checker #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              probe_valid,
    input logic [ADDR_W-1:0] probe_addr,
    input logic              ins_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              wb_valid
);

    // R12: a response follows every probe
    a_r12_rsp_after_probe: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |=> rsp_valid);

    // R11: no probe, no response and no fetch
    a_r11_quiet_without_probe: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_valid |=> (!rsp_valid && !fetch_req));

    // R3: a fetch names the block that was probed
    a_r3_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |=> (!fetch_req || fetch_addr == $past(probe_addr)));

    // R2: a probed request either hits or fetches, never both
    a_r2_hit_xor_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != fetch_req));

    // R7: a hit never pushes an entry out
    a_r7_hit_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !wb_valid);

    // R8: a write-back only follows a supplied displaced line
    a_r8_wb_needs_insert: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid == 1'b0 |=> !wb_valid);

endmodule

bind victim_cache vc_checker #(.ADDR_W(ADDR_W)) u_vc_checker (
    .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid),
    .probe_addr(probe_addr), .ins_valid(ins_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .wb_valid(wb_valid)
);

// File: tb/tb_victim_cache.sv
module tb_victim_cache;
    localparam int N  = 4;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          probe_valid = 1'b0;
    logic [AW-1:0] probe_addr = '0;
    logic          ins_valid = 1'b0;
    logic [AW-1:0] ins_addr = '0;
    logic          ins_dirty = 1'b0;
    logic [DW-1:0] ins_data = '0;
    logic          rsp_valid, rsp_hit, rsp_dirty, fetch_req, wb_valid;
    logic [DW-1:0] rsp_data, wb_data;
    logic [AW-1:0] fetch_addr, wb_addr;

    victim_cache #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid),
        .probe_addr(probe_addr), .ins_valid(ins_valid), .ins_addr(ins_addr),
        .ins_dirty(ins_dirty), .ins_data(ins_data), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .wb_valid(wb_valid),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_cmp = 0;
    int n_bad = 0;

    // Reference buffer: timestamps stand in for recency
    logic          m_v [N];
    logic [AW-1:0] m_a [N];
    logic          m_d [N];
    logic [DW-1:0] m_x [N];
    int            m_t [N];
    int            now = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        int best = 0;
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        for (int i = 1; i < N; i++) if (m_t[i] < m_t[best]) best = i;
        return best;
    endfunction

    // Drive one request at a falling edge, check at the next falling edge
    task automatic do_op(input logic pv, input logic [AW-1:0] pa,
                         input logic iv, input logic [AW-1:0] ia,
                         input logic id, input logic [DW-1:0] ix);
        int h, s;
        logic e_hit, e_dirty, e_wb;
        logic [DW-1:0] e_data, e_wbd;
        logic [AW-1:0] e_wba;
        probe_valid = pv; probe_addr = pa;
        ins_valid = iv; ins_addr = ia; ins_dirty = id; ins_data = ix;
        h = pv ? m_find(pa) : -1;
        e_hit = (h >= 0); e_wb = 1'b0; e_data = '0; e_dirty = 1'b0;
        e_wba = '0; e_wbd = '0;
        if (e_hit) begin
            e_data = m_x[h]; e_dirty = m_d[h];
            m_v[h] = iv; m_a[h] = ia; m_d[h] = iv && id; m_x[h] = ix;
            m_t[h] = ++now;
        end else if (iv) begin
            s = m_victim();
            e_wb = m_v[s] && m_d[s]; e_wba = m_a[s]; e_wbd = m_x[s];
            m_v[s] = 1'b1; m_a[s] = ia; m_d[s] = id; m_x[s] = ix;
            m_t[s] = ++now;
        end
        @(negedge clk);
        probe_valid = 1'b0; ins_valid = 1'b0;
        check("R12 rsp_valid", rsp_valid, pv);
        check("R11 fetch without probe", fetch_req && !pv, 0);
        check("R2/hit flag R3", rsp_hit, e_hit);
        check("R3 fetch_req", fetch_req, pv && !e_hit);
        if (pv && !e_hit) check("R3 fetch_addr", fetch_addr, pa);
        if (e_hit) begin
            check("R2 rsp_data", rsp_data, e_data);
            check("R9 rsp_dirty", rsp_dirty, e_dirty);
        end
        check("R8 wb_valid (R7 on hit)", wb_valid, e_wb);
        if (e_wb) begin
            check("R8 wb_addr", wb_addr, e_wba);
            check("R8 wb_data", wb_data, e_wbd);
        end
    endtask

    // Primary direct-mapped cache model for the sweep
    logic          p_v [4];
    logic [AW-1:0] p_a [4];
    logic          p_d [4];
    logic [DW-1:0] p_x [4];
    logic [DW-1:0] mem [16];
    logic [15:0]   lfsr = 16'hACE1;

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_a[i] = '0; m_d[i] = 0; m_x[i] = '0; m_t[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rsp_valid after reset", rsp_valid, 0);
        check("R1 wb_valid after reset", wb_valid, 0);
        // R1: first probe misses
        do_op(1, 12'h010, 0, '0, 0, '0);
        check("R1 first probe misses", rsp_hit, 0);
        // R11 / R5: plain inserts fill slots 0..3
        do_op(0, '0, 1, 12'h101, 1, 32'h1111_0101);
        check("R11 no response on insert", rsp_valid, 0);
        do_op(0, '0, 1, 12'h102, 0, 32'h1111_0102);
        do_op(0, '0, 1, 12'h103, 0, 32'h1111_0103);
        do_op(0, '0, 1, 12'h104, 0, 32'h1111_0104);
        // R4 / R7: ping-pong swap on a full buffer
        do_op(1, 12'h103, 1, 12'h200, 0, 32'h2222_0200);
        check("R2 hit data", rsp_data, 32'h1111_0103);
        check("R7 no wb on full-buffer hit", wb_valid, 0);
        do_op(1, 12'h200, 1, 12'h103, 1, 32'h3333_0103);
        check("R4 swapped line returned", rsp_data, 32'h2222_0200);
        check("R9 clean line stays clean", rsp_dirty, 0);
        // R5 / R6 / R8: fill on full buffer evicts oldest (0x101, dirty)
        do_op(1, 12'h301, 1, 12'h300, 0, 32'h4444_0300);
        check("R8 dirty eviction", wb_valid, 1);
        check("R6 oldest slot evicted", wb_addr, 12'h101);
        do_op(0, '0, 1, 12'h400, 0, 32'h5555_0400);
        check("R8 clean eviction no wb", wb_valid, 0);
        do_op(1, 12'h102, 0, '0, 0, '0);
        check("R6 0x102 was the LRU victim", rsp_hit, 0);
        // R10: hit without a displaced line frees the slot
        do_op(1, 12'h104, 0, '0, 0, '0);
        check("R10 hit before removal", rsp_hit, 1);
        do_op(1, 12'h104, 0, '0, 0, '0);
        check("R10 removed entry misses", rsp_hit, 0);
        // R5: freed slot reused without eviction
        do_op(0, '0, 1, 12'h500, 0, 32'h6666_0500);
        check("R5 free slot used, no wb", wb_valid, 0);
        do_op(1, 12'h103, 0, '0, 0, '0);
        check("R9 dirty carried through swap", rsp_dirty, 1);
        check("R4 swapped-in data kept", rsp_data, 32'h3333_0103);

        // Sweep: mixed read/write/flush trace through a 4-set primary model
        for (int i = 0; i < 4; i++) begin p_v[i] = 0; p_a[i] = '0; p_d[i] = 0; p_x[i] = '0; end
        for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 + 32'(i * 7);
        for (int k = 0; k < 3000; k++) begin
            int a, st;
            logic [AW-1:0] ba;
            lfsr = lfsr_next(lfsr);
            a = int'(lfsr[3:0]); st = a % 4; ba = AW'(12'h0A0 + a);
            if (lfsr[7:5] == 3'b000) begin
                // R11: primary drops a line without probing
                if (p_v[st]) begin
                    do_op(0, '0, 1, p_a[st], p_d[st], p_x[st]);
                    p_v[st] = 0;
                end
            end else if (!(p_v[st] && p_a[st] == ba)) begin
                int h = m_find(ba);
                logic [DW-1:0] nd = (h >= 0) ? m_x[h] : mem[a];
                logic ndirty = (h >= 0) ? m_d[h] : 1'b0;
                logic wbv;
                int vs = m_victim();
                wbv = (h < 0) && p_v[st] && m_v[vs] && m_d[vs];
                if (wbv) mem[int'(m_a[vs] - 12'h0A0) % 16] = m_x[vs];
                do_op(1, ba, p_v[st], p_a[st], p_d[st], p_x[st]);
                p_v[st] = 1; p_a[st] = ba; p_x[st] = nd; p_d[st] = ndirty;
            end
            if (lfsr[4] && p_v[st] && p_a[st] == ba) begin
                p_x[st] = {lfsr, 16'(k)}; p_d[st] = 1'b1;
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule